// File: doc/BRIEF.md
# Mode-banked register file

This block holds the sixteen 32-bit general registers of a processor core that runs in several privileged operating modes. Some register indices do not always name the same storage. The copy that an index reaches depends on the 5-bit mode input. Fast-interrupt mode has its own copies of indices 8 to 12. Each exception mode has its own pair of indices 13 and 14. User and system mode share one pair. Indices 0 to 7 and index 15 name a single copy that every mode shares. Each exception mode also has its own saved status register, which is read and written through a separate port.

The mode arrives as a plain input. Instruction decode, flag logic and exception entry all live outside this block. The core changes modes by updating its own status register, and the file simply follows the new mode value. The two read ports are combinational. The general write port and the saved-status write port each commit at the rising clock edge, into the bank that the mode selects in that cycle.

Neither port has back-pressure. A write asserted on a cycle is always taken, and a read index is always answered in the same cycle. No ready signal is needed, so each write port carries only an enable.

Top module: `rfb_banked_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every general register in every bank reads zero, and every saved status register reads zero.
- R2: Indices 0 to 7 and index 15 reach one shared copy, whatever the mode.
- R3: In fast-interrupt mode (code 0x11), indices 8 to 12 reach a private copy. Every other mode reaches one shared copy of indices 8 to 12.
- R4: Indices 13 and 14 reach a private copy in each of the modes fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17 and undefined 0x1B. A value written in one of these modes reads back unchanged after passing through the other modes.
- R5: System mode (0x1F) and user mode (0x10) share a single copy of indices 13 and 14.
- R6: Any mode code not listed in R3 to R5 uses the user/system bank.
- R7: Reads are combinational. A write becomes visible only after the rising edge, and it lands in the bank of the mode present in the cycle of the write.
- R8: Each of the five exception modes has its own saved status register. A value written in a mode is returned when that mode is selected again.
- R9: In user, system or unrecognised modes, the saved-status read returns zero and a saved-status write changes nothing.
- R10: The two read ports are independent. Each one returns its own index in the same cycle, including when both ports name the same index.
- R11: When the write enable is low, no register changes, whatever the write index and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | General register write index |
| wr_data_i | input | 32 | General register write data |
| psr_wr_en_i | input | 1 | Saved status write enable |
| psr_wr_data_i | input | 32 | Saved status write data |
| psr_rd_data_o | output | 32 | Saved status of the current mode, or zero |

## Verification
A table of vectors first writes index 13 in every mode with a value that identifies that mode. It then reads every copy back in a different mode order, so any two banks that share storage by mistake show up as a miscompare. Indices 8 and 12 are written in fast-interrupt mode and read from user and interrupt mode, which separates the fast-interrupt range from the shared range. Index 5 and index 15 are read across modes to confirm that they are never banked.

An unlisted mode code writes index 13 and system mode reads the value back, which confirms that unknown codes fall onto the user bank. A write issued in the same cycle as a mode change shows which mode decides the target bank. The saved status registers are filled with a distinct value per mode and read back in reverse order. Writes issued from the non-exception modes must leave those values intact.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int MODE_W   = 5;
  localparam int IDX_W    = 4;

  // Architectural index ranges
  localparam int SHARED_LO_CNT = 8;     // indices below this are never banked
  localparam int FIQ_LO        = 8;
  localparam int FIQ_HI        = 12;
  localparam int HI_CNT        = FIQ_HI - FIQ_LO + 1;
  localparam int SP_IDX        = 13;
  localparam int PC_IDX        = 15;

  localparam int NBANK         = 6;

  // Physical storage layout, derived from the ranges above
  localparam int HI_SHR_BASE   = SHARED_LO_CNT;
  localparam int HI_FIQ_BASE   = HI_SHR_BASE + HI_CNT;
  localparam int SPLR_BASE     = HI_FIQ_BASE + HI_CNT;
  localparam int PC_PHYS       = SPLR_BASE + 2 * NBANK;
  localparam int NPHYS         = PC_PHYS + 1;
  localparam int PHYS_W        = $clog2(NPHYS);

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;

  // Architectural index plus bank -> physical slot
  function automatic logic [PHYS_W-1:0] phys_of(input logic [IDX_W-1:0] idx, input bank_e bk);
    int i;
    int p;
    i = int'(idx);
    if (i < SHARED_LO_CNT)
      p = i;
    else if (i <= FIQ_HI)
      p = ((bk == BK_FIQ) ? HI_FIQ_BASE : HI_SHR_BASE) + i - FIQ_LO;
    else if (i == PC_IDX)
      p = PC_PHYS;
    else
      p = SPLR_BASE + 2 * int'(bk) + i - SP_IDX;
    return PHYS_W'(p);
  endfunction
endpackage

// File: rtl/rfb_mode_decode.sv
module rfb_mode_decode
  import rfb_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o,
  output logic              priv_o
);
  always_comb begin
    case (mode_i)
      MD_FIQ:  bank_o = BK_FIQ;
      MD_IRQ:  bank_o = BK_IRQ;
      MD_SVC:  bank_o = BK_SVC;
      MD_ABT:  bank_o = BK_ABT;
      MD_UND:  bank_o = BK_UND;
      default: bank_o = BK_USR;   // user, system and any unknown code
    endcase
    priv_o = (bank_o != BK_USR);
  end
endmodule

// File: rtl/rfb_index_map.sv
module rfb_index_map
  import rfb_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  bank_e             bank_i,
  output logic [PHYS_W-1:0] phys_o
);
  assign phys_o = phys_of(idx_i, bank_i);
endmodule

// File: rtl/rfb_reg_store.sv
module rfb_reg_store
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_RD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [PHYS_W-1:0] wr_phys_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PHYS_W-1:0] rd_phys_i [N_RD],
  output logic [DATA_W-1:0] rd_data_o [N_RD]
);
  logic [NPHYS-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mem_q <= '0;
    else if (wr_en_i) mem_q[wr_phys_i] <= wr_data_i;
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_phys_i[r]];
  end

  // The slot written at an edge holds the written data one cycle later
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> mem_q[$past(wr_phys_i)] == $past(wr_data_i));

  // No enable, no change anywhere in the array
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/rfb_spsr_bank.sv
module rfb_spsr_bank
  import rfb_pkg::*;
#(
  parameter int PSR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bank_e            bank_i,
  input  logic             priv_i,
  input  logic             we_i,
  input  logic [PSR_W-1:0] wdata_i,
  output logic [PSR_W-1:0] rdata_o
);
  // Slot 0 (user/system) has no saved status; storage starts at 1
  logic [NBANK-1:1][PSR_W-1:0] spsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spsr_q <= '0;
    end else begin
      for (int b = 1; b < NBANK; b++)
        if (we_i && priv_i && bank_i == bank_e'(b)) spsr_q[b] <= wdata_i;
    end
  end

  assign rdata_o = priv_i ? spsr_q[bank_i] : '0;

  // Writes from a mode without a saved status leave all slots alone
  assert_unpriv_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !priv_i) |=> $stable(spsr_q));

  // A write is read back in the next cycle while the bank holds
  assert_spsr_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && priv_i) |=> (!$stable(bank_i) || rdata_o == $past(wdata_i)));
endmodule

// File: rtl/rfb_banked_regfile.sv
module rfb_banked_regfile
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              psr_wr_en_i,
  input  logic [PSR_W-1:0]  psr_wr_data_i,
  output logic [PSR_W-1:0]  psr_rd_data_o
);
  localparam int N_RD   = 2;
  localparam int N_PORT = N_RD + 1;   // read ports then the write port

  bank_e             bank;
  logic              priv;
  logic [IDX_W-1:0]  port_idx  [N_PORT];
  logic [PHYS_W-1:0] port_phys [N_PORT];
  logic [PHYS_W-1:0] rd_phys   [N_RD];
  logic [DATA_W-1:0] rd_data   [N_RD];

  rfb_mode_decode u_decode (
    .mode_i (mode_i),
    .bank_o (bank),
    .priv_o (priv)
  );

  assign port_idx[0] = rd_a_idx_i;
  assign port_idx[1] = rd_b_idx_i;
  assign port_idx[2] = wr_idx_i;

  for (genvar p = 0; p < N_PORT; p++) begin : g_map
    rfb_index_map u_map (
      .idx_i  (port_idx[p]),
      .bank_i (bank),
      .phys_o (port_phys[p])
    );
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rdp
    assign rd_phys[r] = port_phys[r];
  end

  rfb_reg_store #(.DATA_W(DATA_W), .N_RD(N_RD)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_phys_i (port_phys[N_RD]),
    .wr_data_i (wr_data_i),
    .rd_phys_i (rd_phys),
    .rd_data_o (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  rfb_spsr_bank #(.PSR_W(PSR_W)) u_spsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank_i  (bank),
    .priv_i  (priv),
    .we_i    (psr_wr_en_i),
    .wdata_i (psr_wr_data_i),
    .rdata_o (psr_rd_data_o)
  );

  // Port-level read-after-write: same mode, same index -> the written value
  assert_port_a_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (!$stable(mode_i) || rd_a_idx_i != $past(wr_idx_i) ||
                 rd_a_data_o == $past(wr_data_i)));

  assert_port_b_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (!$stable(mode_i) || rd_b_idx_i != $past(wr_idx_i) ||
                 rd_b_data_o == $past(wr_data_i)));
endmodule

// File: tb/test_rfb_banked_regfile.sv
module test_rfb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = 5'h10;
  logic [3:0]  ra = '0, rb = '0, widx = '0;
  logic        we = 1'b0, pwe = 1'b0;
  logic [31:0] wdata = '0, pdata = '0;
  logic [31:0] rda, rdb, prd;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rfb_banked_regfile i_rfb_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .rd_a_idx_i(ra), .rd_a_data_o(rda),
    .rd_b_idx_i(rb), .rd_b_data_o(rdb),
    .wr_en_i(we), .wr_idx_i(widx), .wr_data_i(wdata),
    .psr_wr_en_i(pwe), .psr_wr_data_i(pdata), .psr_rd_data_o(prd)
  );

  // {mode, we, widx, wdata, ridx, expected port A before the edge, req}
  localparam int NV = 29;
  localparam logic [81:0] VEC [NV] = '{
    {5'h10, 1'b1, 4'd13, 32'h1000_0010, 4'd13, 32'h0,          4'd1},  // R1 usr r13 clean
    {5'h13, 1'b1, 4'd13, 32'h0000_0013, 4'd13, 32'h0,          4'd4},  // R4
    {5'h17, 1'b1, 4'd13, 32'h0000_0017, 4'd13, 32'h0,          4'd4},
    {5'h1B, 1'b1, 4'd13, 32'h0000_001B, 4'd13, 32'h0,          4'd4},
    {5'h12, 1'b1, 4'd13, 32'h0000_0012, 4'd13, 32'h0,          4'd4},
    {5'h11, 1'b1, 4'd13, 32'h0000_0011, 4'd13, 32'h0,          4'd4},
    {5'h1F, 1'b1, 4'd14, 32'h0000_1F14, 4'd13, 32'h1000_0010,  4'd5},  // R5 sys sees usr r13
    {5'h11, 1'b1, 4'd8,  32'h0000_00F8, 4'd8,  32'h0,          4'd3},  // R3
    {5'h10, 1'b1, 4'd8,  32'h0000_0AA8, 4'd8,  32'h0,          4'd3},
    {5'h12, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_0AA8,  4'd3},
    {5'h11, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_00F8,  4'd3},
    {5'h13, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_0013,  4'd4},
    {5'h17, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_0017,  4'd4},
    {5'h1B, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_001B,  4'd4},
    {5'h12, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_0012,  4'd4},
    {5'h11, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_0011,  4'd4},
    {5'h10, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0000_1F14,  4'd5},
    {5'h00, 1'b0, 4'd0,  32'h0,         4'd13, 32'h1000_0010,  4'd6},  // R6 unknown code
    {5'h15, 1'b1, 4'd13, 32'h0000_0055, 4'd13, 32'h1000_0010,  4'd6},
    {5'h1F, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_0055,  4'd6},
    {5'h11, 1'b1, 4'd5,  32'h0000_0005, 4'd5,  32'h0,          4'd2},  // R2
    {5'h13, 1'b0, 4'd0,  32'h0,         4'd5,  32'h0000_0005,  4'd2},
    {5'h17, 1'b1, 4'd15, 32'h0000_0F15, 4'd15, 32'h0,          4'd2},
    {5'h11, 1'b0, 4'd0,  32'h0,         4'd15, 32'h0000_0F15,  4'd2},
    {5'h11, 1'b1, 4'd12, 32'h0000_0C12, 4'd12, 32'h0,          4'd3},
    {5'h1F, 1'b0, 4'd0,  32'h0,         4'd12, 32'h0,          4'd3},
    {5'h13, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0,          4'd4},
    {5'h11, 1'b0, 4'd0,  32'h0000_DEAD, 4'd0,  32'h0,          4'd11}, // R11 enable low
    {5'h10, 1'b0, 4'd0,  32'h0,         4'd0,  32'h0,          4'd11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic psr_write(input logic [4:0] m, input logic [31:0] d);
    @(negedge clk);
    mode = m; pdata = d; pwe = 1'b1;
    @(negedge clk);
    pwe = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, during and after reset
    #12;
    ra = 4'd13; #1; check("R1", rda, 32'h0);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++) begin
      mode = (m == 0) ? 5'h10 : 5'h11;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        ra = 4'(i); rb = 4'(15 - i); #1;
        check("R1", rda, 32'h0);
        check("R1", rdb, 32'h0);
      end
    end
    mode = 5'h13; #1; check("R1", prd, 32'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode = VEC[v][81:77]; we = VEC[v][76]; widx = VEC[v][75:72];
      wdata = VEC[v][71:40]; ra = VEC[v][39:36];
      #1;
      check($sformatf("R%0d", VEC[v][3:0]), rda, VEC[v][35:4]);
    end
    @(negedge clk); we = 1'b0;

    // R7: old value before the edge, new value after, inputs unchanged
    mode = 5'h13; ra = 4'd3; widx = 4'd3; wdata = 32'h33; we = 1'b1; #1;
    check("R7", rda, 32'h0);
    @(posedge clk); #1;
    check("R7", rda, 32'h33);
    @(negedge clk); we = 1'b0;
    // R7: write lands in the mode of its own cycle
    mode = 5'h17; widx = 4'd14; wdata = 32'hAB14; we = 1'b1;
    @(negedge clk); we = 1'b0; mode = 5'h13; ra = 4'd14; #1;
    check("R7", rda, 32'h0);
    @(negedge clk); mode = 5'h17; #1;
    check("R7", rda, 32'hAB14);

    // R10: two ports, different and identical indices
    @(negedge clk); mode = 5'h11; ra = 4'd8; rb = 4'd13; #1;
    check("R10", rda, 32'hF8);
    check("R10", rdb, 32'h11);
    rb = 4'd8; #1;
    check("R10", rdb, 32'hF8);
    check("R10", rda, 32'hF8);

    // R8: one saved status per exception mode
    psr_write(5'h13, 32'h1);
    psr_write(5'h17, 32'h2);
    psr_write(5'h1B, 32'h3);
    psr_write(5'h12, 32'h4);
    psr_write(5'h11, 32'h5);
    mode = 5'h11; #1; check("R8", prd, 32'h5);
    mode = 5'h12; #1; check("R8", prd, 32'h4);
    mode = 5'h1B; #1; check("R8", prd, 32'h3);
    mode = 5'h17; #1; check("R8", prd, 32'h2);
    mode = 5'h13; #1; check("R8", prd, 32'h1);

    // R9: non-exception modes read zero and cannot write
    psr_write(5'h1F, 32'h6);
    #1; check("R9", prd, 32'h0);
    mode = 5'h10; #1; check("R9", prd, 32'h0);
    psr_write(5'h00, 32'h77);
    #1; check("R9", prd, 32'h0);
    mode = 5'h13; #1; check("R9", prd, 32'h1);
    mode = 5'h11; #1; check("R9", prd, 32'h5);

    // R1: reset in mid-run clears banked copies and saved status
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    mode = 5'h11; ra = 4'd13; rb = 4'd8; #1;
    check("R1", rda, 32'h0);
    check("R1", rdb, 32'h0);
    check("R1", prd, 32'h0);
    mode = 5'h10; ra = 4'd15; #1;
    check("R1", rda, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule